// File: doc/BRIEF.md
# Memory Pointer Write Protection Checker

This block grants or refuses each memory command of a small serial non-volatile memory before the command reaches the array. A movable boundary register splits the address space in two. When no access code is in force (unprotected), the region below the boundary can only be read and the region at or above it is fully open. When an access code is in force (secure), the region at or above the boundary can only be read until a valid code has been presented. The region below it is closed to every operation until then. Program and erase also require a separate enable latch.

Other logic decodes the commands and the access code, and it supplies an opcode, an address, a secure-mode level and a code-match flag. The block keeps the boundary register, the program/erase enable latch, the access-enabled flag, an access lock and a byte/word organization bit. It also keeps a single-use override and a pending flag for bulk erase. For every command it returns a grant bit or an instruction-error strobe, one cycle later. A pointer-read command returns the boundary register. A chip-select reset clears only the command-sequence state.

Top module: `ptr_guard`

## Requirements
- R1: After `rst`, the boundary register is 0, the enable latch, access flag and lock are clear, and the organization is byte mode. A read is granted and a write is refused. Every response appears on `rsp_*` in the cycle after `cmd_valid`.
- R2: Opcodes are NOP=0, READ=1, WRITE=2, ERASE=3, ERAL=4, WRAL=5, WMPR=6, RMPR=7, OVMPR=8, EWEN=9, EWDS=10, ENAC=11, DISAC=12, ORG=13. Codes 14 and 15 raise `rsp_ierr` with `rsp_allow` low, and they change no state.
- R3: In unprotected mode (`secure`=0), READ is granted at any address. WRITE and ERASE are granted at or above the boundary when the enable latch is set, and are refused below it.
- R4: In secure mode, without access, READ is granted only at or above the boundary and WRITE/ERASE are refused everywhere. ENAC with `cmd_code_ok`=1 sets access, after which READ is granted everywhere and WRITE/ERASE follow the R3 boundary rule. ENAC with `cmd_code_ok`=0 is refused.
- R5: EWEN sets the enable latch and EWDS clears it. No WRITE, ERASE, ERAL or WRAL is granted while the latch is clear. A chip-select reset leaves the latch unchanged.
- R6: A granted OVMPR lets exactly one following WRITE or ERASE pass below the boundary. The next WRITE or ERASE, granted or not, clears the override.
- R7: WMPR loads the boundary from `cmd_addr`. In secure mode without access, both WMPR and OVMPR are refused and change nothing. RMPR is always granted and returns the boundary on `rsp_ptr`.
- R8: A first ERAL only sets a pending flag and is not granted. An ERAL or WRAL that directly follows it is granted and clears the flag. Any other command in between clears the flag.
- R9: A granted ERAL or WRAL does not depend on the boundary.
- R10: DISAC clears access and sets a lock that refuses every program/erase command. An ENAC with `cmd_code_ok`=1 releases the lock.
- R11: ORG takes `cmd_addr[0]` as the organization (0 byte, 1 word). In word mode, address comparisons and WMPR use only the low 8 address bits, and the stored boundary has bit 8 cleared.
- R12: `cs_rst` clears the override and the pending flag and discards any command in the same cycle. The boundary, latch, access, lock and organization are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cs_rst | input | 1 | Chip-select reset pulse |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 4 | Command opcode |
| cmd_addr | input | 9 | Command address (ORG uses bit 0) |
| cmd_code_ok | input | 1 | Access code matched (qualifies ENAC) |
| secure | input | 1 | An access code is in force |
| rsp_valid | output | 1 | Response to the previous cycle's command |
| rsp_allow | output | 1 | Command granted |
| rsp_ierr | output | 1 | Illegal opcode strobe |
| rsp_ptr | output | 9 | Boundary value after RMPR, else 0 |

## Verification
Each grant, error strobe and pointer value is registered once, so it is due on the clock edge that follows the command cycle. State changes show up in the response to the next command. The bench drives a command on a falling edge and reads the response on the next falling edge, which lies just past the single capturing edge. Every state effect (override use, pending flag, latch, lock, boundary) is judged only through the grant of a later command or through RMPR.

// File: rtl/ptr_guard_pkg.sv
package ptr_guard_pkg;

    localparam int GUARD_AW = 9;
    localparam int OP_W     = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 4'd0,
        OP_READ  = 4'd1,
        OP_WRITE = 4'd2,
        OP_ERASE = 4'd3,
        OP_ERAL  = 4'd4,
        OP_WRAL  = 4'd5,
        OP_WMPR  = 4'd6,
        OP_RMPR  = 4'd7,
        OP_OVMPR = 4'd8,
        OP_EWEN  = 4'd9,
        OP_EWDS  = 4'd10,
        OP_ENAC  = 4'd11,
        OP_DISAC = 4'd12,
        OP_ORG   = 4'd13
    } guard_op_e;

    typedef struct packed {
        logic [GUARD_AW-1:0] ptr;
        logic                word_mode;
        logic                pe_en;
        logic                acc_en;
        logic                acc_lock;
        logic                ovr;
        logic                bulk_pend;
    } guard_st_t;

    localparam guard_st_t GUARD_RST = '{default: '0};

    function automatic logic op_legal(input logic [OP_W-1:0] raw);
        return int'(raw) <= int'(OP_ORG);
    endfunction

    function automatic logic below_ptr(input logic [GUARD_AW-1:0] a,
                                       input logic [GUARD_AW-1:0] p,
                                       input logic word);
        if (word) return a[GUARD_AW-2:0] < p[GUARD_AW-2:0];
        return a < p;
    endfunction

    function automatic logic [GUARD_AW-1:0] fit_addr(input logic [GUARD_AW-1:0] a,
                                                     input logic word);
        return word ? {1'b0, a[GUARD_AW-2:0]} : a;
    endfunction

endpackage

// File: rtl/ptr_guard_rules.sv
module ptr_guard_rules
    import ptr_guard_pkg::*;
(
    input  logic [OP_W-1:0]     op,
    input  logic [GUARD_AW-1:0] addr,
    input  logic                secure,
    input  logic                code_ok,
    input  guard_st_t           st,
    output logic                allow,
    output logic                ierr,
    output guard_st_t           nx
);

    logic below;
    logic pe_ok;
    logic priv;

    always_comb begin
        below = below_ptr(addr, st.ptr, st.word_mode);
        pe_ok = st.pe_en && !st.acc_lock;
        priv  = !secure || st.acc_en;

        nx           = st;
        nx.bulk_pend = 1'b0;
        allow        = 1'b0;
        ierr         = 1'b0;

        case (op)
            OP_NOP:   allow = 1'b1;
            OP_READ:  allow = !secure || !below || st.acc_en;
            OP_WRITE,
            OP_ERASE: begin
                allow  = pe_ok && priv && (!below || st.ovr);
                nx.ovr = 1'b0;
            end
            OP_ERAL: begin
                allow        = st.bulk_pend && pe_ok;
                nx.bulk_pend = !st.bulk_pend;
            end
            OP_WRAL:  allow = st.bulk_pend && pe_ok;
            OP_WMPR: begin
                allow = priv;
                if (priv) nx.ptr = fit_addr(addr, st.word_mode);
            end
            OP_RMPR:  allow = 1'b1;
            OP_OVMPR: begin
                allow = priv;
                if (priv) nx.ovr = 1'b1;
            end
            OP_EWEN: begin
                allow    = 1'b1;
                nx.pe_en = 1'b1;
            end
            OP_EWDS: begin
                allow    = 1'b1;
                nx.pe_en = 1'b0;
            end
            OP_ENAC: begin
                allow = code_ok;
                if (code_ok) begin
                    nx.acc_en   = 1'b1;
                    nx.acc_lock = 1'b0;
                end
            end
            OP_DISAC: begin
                allow       = 1'b1;
                nx.acc_en   = 1'b0;
                nx.acc_lock = 1'b1;
            end
            OP_ORG: begin
                allow        = 1'b1;
                nx.word_mode = addr[0];
                nx.ptr       = fit_addr(st.ptr, addr[0]);
            end
            default: begin
                ierr = 1'b1;
                nx   = st;
            end
        endcase
    end

endmodule

// File: rtl/ptr_guard_regs.sv
module ptr_guard_regs
    import ptr_guard_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_rst,
    input  logic      upd,
    input  guard_st_t nx,
    output guard_st_t st
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= GUARD_RST;
        end else if (cs_rst) begin
            st.ovr       <= 1'b0;
            st.bulk_pend <= 1'b0;
        end else if (upd) begin
            st <= nx;
        end
    end

    // R1
    ptr_rst_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (st.ptr == '0 && !st.pe_en && !st.acc_en && !st.word_mode));

    // R5
    pe_keep_chk: assert property (@(posedge clk) disable iff (rst)
        cs_rst |=> (st.pe_en == $past(st.pe_en)));

    // R12
    seq_clr_chk: assert property (@(posedge clk) disable iff (rst)
        cs_rst |=> (!st.ovr && !st.bulk_pend && st.ptr == $past(st.ptr)));

endmodule

// File: rtl/ptr_guard.sv
module ptr_guard
    import ptr_guard_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_rst,
    input  logic                cmd_valid,
    input  logic [OP_W-1:0]     cmd_op,
    input  logic [GUARD_AW-1:0] cmd_addr,
    input  logic                cmd_code_ok,
    input  logic                secure,
    output logic                rsp_valid,
    output logic                rsp_allow,
    output logic                rsp_ierr,
    output logic [GUARD_AW-1:0] rsp_ptr
);

    guard_st_t st;
    guard_st_t nx;
    logic      allow;
    logic      ierr;
    logic      take;

    assign take = cmd_valid && !cs_rst;

    ptr_guard_rules u_rules (
        .op      (cmd_op),
        .addr    (cmd_addr),
        .secure  (secure),
        .code_ok (cmd_code_ok),
        .st      (st),
        .allow   (allow),
        .ierr    (ierr),
        .nx      (nx)
    );

    ptr_guard_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .cs_rst (cs_rst),
        .upd    (take),
        .nx     (nx),
        .st     (st)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_allow <= 1'b0;
            rsp_ierr  <= 1'b0;
            rsp_ptr   <= '0;
        end else begin
            rsp_valid <= take;
            rsp_allow <= take && allow;
            rsp_ierr  <= take && ierr;
            rsp_ptr   <= (take && cmd_op == OP_RMPR) ? st.ptr : '0;
        end
    end

    // R2
    ierr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_ierr |-> (!rsp_allow && rsp_valid));

    // R2
    ierr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !op_legal(cmd_op)) |=> (st == $past(st)));

    // R6
    ovr_once_chk: assert property (@(posedge clk) disable iff (rst)
        (take && (cmd_op == OP_WRITE || cmd_op == OP_ERASE)) |=> !st.ovr);

    // R5
    pe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !(st.pe_en && !st.acc_lock) &&
         (cmd_op == OP_WRITE || cmd_op == OP_ERASE || cmd_op == OP_ERAL || cmd_op == OP_WRAL))
        |=> !rsp_allow);

    // R7
    wmpr_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (take && secure && !st.acc_en && cmd_op == OP_WMPR) |=> (st.ptr == $past(st.ptr)));

endmodule

// File: tb/ptr_guard_tb.sv
module ptr_guard_tb;

    localparam logic [3:0] C_NOP = 4'd0, C_READ = 4'd1, C_WRITE = 4'd2, C_ERASE = 4'd3,
                           C_ERAL = 4'd4, C_WRAL = 4'd5, C_WMPR = 4'd6, C_RMPR = 4'd7,
                           C_OVMPR = 4'd8, C_EWEN = 4'd9, C_EWDS = 4'd10, C_ENAC = 4'd11,
                           C_DISAC = 4'd12, C_ORG = 4'd13;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_rst = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_op = '0;
    logic [8:0] cmd_addr = '0;
    logic       cmd_code_ok = 1'b0;
    logic       secure = 1'b0;
    logic       rsp_valid, rsp_allow, rsp_ierr;
    logic [8:0] rsp_ptr;

    logic       g_valid, g_allow, g_ierr;
    logic [8:0] g_ptr;
    int         nchk = 0;
    int         nerr = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    ptr_guard u_dut (
        .clk(clk), .rst(rst), .cs_rst(cs_rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_code_ok(cmd_code_ok), .secure(secure),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_ierr(rsp_ierr), .rsp_ptr(rsp_ptr)
    );

    task automatic chk(input string tag, input logic [8:0] got, input logic [8:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic send(input logic [3:0] op, input logic [8:0] a, input logic ok);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_code_ok = ok;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code_ok = 1'b0;
        g_valid = rsp_valid; g_allow = rsp_allow; g_ierr = rsp_ierr; g_ptr = rsp_ptr;
    endtask

    task automatic expect_grant(input string tag, input logic [3:0] op,
                                input logic [8:0] a, input logic ok, input logic exp);
        send(op, a, ok);
        chk({tag, " valid"}, {8'd0, g_valid}, 9'd1);
        chk(tag, {8'd0, g_allow}, {8'd0, exp});
    endtask

    task automatic pulse_cs();
        @(negedge clk); cs_rst = 1'b1;
        @(negedge clk); cs_rst = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 idle rsp_valid", {8'd0, rsp_valid}, 9'd0);
        send(C_RMPR, 9'd0, 1'b0);
        chk("R1 pointer after reset", g_ptr, 9'd0);
        expect_grant("R1 read after reset", C_READ, 9'd5, 1'b0, 1'b1);
        expect_grant("R1 write after reset", C_WRITE, 9'd5, 1'b0, 1'b0);
    endtask

    task automatic t_illegal();
        send(4'd14, 9'h055, 1'b1);
        chk("R2 code 14 ierr", {8'd0, g_ierr}, 9'd1);
        chk("R2 code 14 allow", {8'd0, g_allow}, 9'd0);
        send(4'd15, 9'h055, 1'b1);
        chk("R2 code 15 ierr", {8'd0, g_ierr}, 9'd1);
        send(C_RMPR, 9'd0, 1'b0);
        chk("R2 pointer unchanged", g_ptr, 9'd0);
        chk("R2 legal op no ierr", {8'd0, g_ierr}, 9'd0);
    endtask

    task automatic t_unprot();
        expect_grant("R5 ewen", C_EWEN, 9'd0, 1'b0, 1'b1);
        expect_grant("R7 wmpr unprotected", C_WMPR, 9'h040, 1'b0, 1'b1);
        send(C_RMPR, 9'd0, 1'b0);
        chk("R7 rmpr value", g_ptr, 9'h040);
        expect_grant("R3 write at pointer", C_WRITE, 9'h040, 1'b0, 1'b1);
        expect_grant("R3 erase below pointer", C_ERASE, 9'h03F, 1'b0, 1'b0);
        expect_grant("R3 read below pointer", C_READ, 9'h010, 1'b0, 1'b1);
    endtask

    task automatic t_override();
        expect_grant("R6 ovmpr", C_OVMPR, 9'd0, 1'b0, 1'b1);
        expect_grant("R6 first write below", C_WRITE, 9'h010, 1'b0, 1'b1);
        expect_grant("R6 second write below", C_WRITE, 9'h010, 1'b0, 1'b0);
    endtask

    task automatic t_cs();
        expect_grant("R12 ovmpr", C_OVMPR, 9'd0, 1'b0, 1'b1);
        pulse_cs();
        expect_grant("R12 override cleared", C_WRITE, 9'h010, 1'b0, 1'b0);
        expect_grant("R5 latch survives cs", C_WRITE, 9'h080, 1'b0, 1'b1);
        expect_grant("R12 eral arm", C_ERAL, 9'd0, 1'b0, 1'b0);
        pulse_cs();
        expect_grant("R12 pending cleared", C_ERAL, 9'd0, 1'b0, 1'b0);
        expect_grant("R8 second eral", C_ERAL, 9'd0, 1'b0, 1'b1);
    endtask

    task automatic t_bulk();
        expect_grant("R8 eral arm", C_ERAL, 9'd0, 1'b0, 1'b0);
        expect_grant("R9 eral ignores pointer", C_ERAL, 9'd0, 1'b0, 1'b1);
        expect_grant("R8 eral before wral", C_ERAL, 9'd0, 1'b0, 1'b0);
        expect_grant("R9 wral ignores pointer", C_WRAL, 9'd0, 1'b0, 1'b1);
        expect_grant("R8 lone wral", C_WRAL, 9'd0, 1'b0, 1'b0);
        expect_grant("R8 eral arm again", C_ERAL, 9'd0, 1'b0, 1'b0);
        expect_grant("R8 nop between", C_NOP, 9'd0, 1'b0, 1'b1);
        expect_grant("R8 eral after nop", C_ERAL, 9'd0, 1'b0, 1'b0);
        expect_grant("R8 clear pending", C_NOP, 9'd0, 1'b0, 1'b1);
    endtask

    task automatic t_ewds();
        expect_grant("R5 ewds", C_EWDS, 9'd0, 1'b0, 1'b1);
        expect_grant("R5 write with latch clear", C_WRITE, 9'h080, 1'b0, 1'b0);
        expect_grant("R5 eral arm latch clear", C_ERAL, 9'd0, 1'b0, 1'b0);
        expect_grant("R5 eral latch clear", C_ERAL, 9'd0, 1'b0, 1'b0);
        expect_grant("R5 ewen again", C_EWEN, 9'd0, 1'b0, 1'b1);
    endtask

    task automatic t_secure();
        @(negedge clk); secure = 1'b1;
        expect_grant("R4 read below no access", C_READ, 9'h010, 1'b0, 1'b0);
        expect_grant("R4 read above no access", C_READ, 9'h080, 1'b0, 1'b1);
        expect_grant("R4 write above no access", C_WRITE, 9'h080, 1'b0, 1'b0);
        expect_grant("R7 wmpr no access", C_WMPR, 9'h020, 1'b0, 1'b0);
        expect_grant("R7 ovmpr no access", C_OVMPR, 9'd0, 1'b0, 1'b0);
        send(C_RMPR, 9'd0, 1'b0);
        chk("R7 pointer kept", g_ptr, 9'h040);
        expect_grant("R4 enac bad code", C_ENAC, 9'd0, 1'b0, 1'b0);
        expect_grant("R4 read below bad code", C_READ, 9'h010, 1'b0, 1'b0);
        expect_grant("R4 enac good code", C_ENAC, 9'd0, 1'b1, 1'b1);
        expect_grant("R4 read below access", C_READ, 9'h010, 1'b0, 1'b1);
        expect_grant("R4 write above access", C_WRITE, 9'h080, 1'b0, 1'b1);
        expect_grant("R4 write below access", C_WRITE, 9'h010, 1'b0, 1'b0);
        expect_grant("R7 ovmpr access", C_OVMPR, 9'd0, 1'b0, 1'b1);
        expect_grant("R6 secure override write", C_WRITE, 9'h010, 1'b0, 1'b1);
    endtask

    task automatic t_disac();
        expect_grant("R10 disac", C_DISAC, 9'd0, 1'b0, 1'b1);
        expect_grant("R10 write locked", C_WRITE, 9'h080, 1'b0, 1'b0);
        expect_grant("R10 eral arm locked", C_ERAL, 9'd0, 1'b0, 1'b0);
        expect_grant("R10 eral locked", C_ERAL, 9'd0, 1'b0, 1'b0);
        expect_grant("R10 access dropped", C_READ, 9'h010, 1'b0, 1'b0);
        expect_grant("R10 enac unlock", C_ENAC, 9'd0, 1'b1, 1'b1);
        expect_grant("R10 write after unlock", C_WRITE, 9'h080, 1'b0, 1'b1);
        @(negedge clk); secure = 1'b0;
    endtask

    task automatic t_org();
        expect_grant("R11 org word", C_ORG, 9'd1, 1'b0, 1'b1);
        expect_grant("R11 wmpr word", C_WMPR, 9'h1C0, 1'b0, 1'b1);
        send(C_RMPR, 9'd0, 1'b0);
        chk("R11 pointer bit 8 cleared", g_ptr, 9'h0C0);
        expect_grant("R11 word write at pointer", C_WRITE, 9'h1C0, 1'b0, 1'b1);
        expect_grant("R11 word write low bits below", C_WRITE, 9'h100, 1'b0, 1'b0);
        expect_grant("R11 org byte", C_ORG, 9'd0, 1'b0, 1'b1);
        expect_grant("R11 byte write above", C_WRITE, 9'h100, 1'b0, 1'b1);
        expect_grant("R11 byte write below", C_WRITE, 9'h0BF, 1'b0, 1'b0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_illegal();
        t_unprot();
        t_override();
        t_cs();
        t_bulk();
        t_ewds();
        t_secure();
        t_disac();
        t_org();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

endmodule